// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides which side owns a shared off-chip bus: the on-chip master or a single external master. The external master uses three active-low lines. It pulls a request line low to ask for the bus. It receives an active-low grant. It holds a busy line low while it is driving the bus. The on-chip master presents a pending-access flag and a two-bit access kind. A three-bit external priority, set by configuration, is compared against a fixed priority attached to that kind. The external master wins only when its priority is strictly higher than the internal one.

Both request and busy arrive asynchronously and each passes through a two-stage synchronizer before the state machine sees it. The state machine has four states: idle (bus parked on the internal side), internal owner, external owner, and a reclaim wait. When the internal side takes the bus back from the external master, it first withdraws the grant. It then waits in the reclaim state until the external master lets busy go high, and only then drives the bus. A parked access may go ahead from idle without any ownership handshake. The block carries no data, address or transfer-size logic. It produces ownership decisions only.

Top module: `ext_bus_arbiter`

## Requirements
- R1: Reset is synchronous and active low. After any clock edge with `rst_n` low, the arbiter is idle: `ext_grant_n` = 1, `busy_drive_en` = 0, and both synchronizers hold the inactive (high) level.
- R2: `int_kind` encoding and fixed internal priority: 2'b00 instruction fetch = 3, 2'b01 data access = 4, 2'b10 parked access = 0, 2'b11 treated as a data access = 4. The kind is ignored while `int_req` is 0.
- R3: In idle or internal ownership, the arbiter moves to external ownership (`ext_grant_n` = 0) when the synchronized request is low and either no internal access is pending or `ext_prio` is strictly greater than the internal priority. Equal priorities go to the internal side.
- R4: `ext_req_n` and `ext_busy_n` each pass through two flops. A level change set up before clock edge k is acted on at edge k+2, so the outputs reflect it after edge k+2.
- R5: In idle with no request from either side, the arbiter stays idle: grant high and busy not driven. While idle, `int_proceed` is 1 only if a parked access (kind 2'b10) is pending.
- R6: A pending internal access that does not lose under R3 moves idle to internal ownership, where `busy_drive_en` = 1 and `int_proceed` = 1. Dropping `int_req` returns the arbiter to idle.
- R7: In external ownership, a pending internal access whose priority is greater than or equal to `ext_prio` moves the arbiter to the reclaim wait. There `ext_grant_n` = 1, `busy_drive_en` = 0 and `int_proceed` = 0. It stays there while the synchronized busy is low. Once busy is high, it goes to internal ownership if `int_req` is 1, otherwise to idle.
- R8: In external ownership with no reclaim, synchronized request high together with synchronized busy high returns the arbiter to idle. While either line is still low, ownership stays with the external master.
- R9: Internal ownership hands over directly to external ownership when R3 is met, and `busy_drive_en` never rises in the cycle right after a grant was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req_n | input | 1 | External bus request, active low, asynchronous |
| ext_busy_n | input | 1 | Bus busy line as seen at the pad, low while a master drives the bus, asynchronous |
| int_req | input | 1 | Internal master has an access pending |
| int_kind | input | 2 | Kind of the pending internal access (see R2) |
| ext_prio | input | 3 | Programmed external arbitration priority, 0 to 7 |
| ext_grant_n | output | 1 | Bus grant to the external master, active low |
| busy_drive_en | output | 1 | When 1 the pad pulls busy low; when 0 busy is left three-stated |
| int_proceed | output | 1 | The internal master may drive the bus this cycle |

## Verification
The hardest condition to reach from the ports is the reclaim wait with the external master still holding busy low. To get there, the stimulus first grants the bus at a high external priority. It keeps busy low and raises an equal-priority data access, then holds busy low for many cycles while the arbiter must sit in the wait state. A second pass drops the internal request during the wait, so the exit must fall back to idle. A behavioural model in the bench uses queues to reproduce the two-edge synchronizer delay. It is compared on every cycle, both for these directed sequences and for a long run of random request, busy, kind and priority values.

// File: rtl/arb_pkg.sv
// Package: shared types for the external bus ownership arbiter.
// Assumes: two-bit access kind coding fixed by the block's requirements.
package arb_pkg;

    // Arbiter states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_EXT  = 2'd2,
        ST_WAIT = 2'd3
    } arb_state_t;

    // Internal access kinds
    typedef enum logic [1:0] {
        K_INSTR  = 2'd0,
        K_DATA   = 2'd1,
        K_PARKED = 2'd2,
        K_RSVD   = 2'd3
    } access_kind_t;

endpackage

// File: rtl/arb_sync.sv
// Module: arb_sync
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes: inputs are levels held for several cycles; reset loads RST_VAL.
module arb_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/arb_prio.sv
// Module: arb_prio
// Maps the pending internal access kind to its fixed priority and compares
// it with the programmed external priority.
// Assumes: ties favour the internal master; no pending access loses to any
// external request.
module arb_prio
    import arb_pkg::*;
#(
    parameter int                PRIO_W   = 3,
    parameter logic [PRIO_W-1:0] P_INSTR  = 3,
    parameter logic [PRIO_W-1:0] P_DATA   = 4,
    parameter logic [PRIO_W-1:0] P_PARKED = 0
) (
    input  logic              int_req,
    input  access_kind_t      int_kind,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic              ext_wins,
    output logic              int_reclaims
);

    logic [PRIO_W-1:0] int_prio;

    // Fixed priority lookup; the reserved code behaves as a data access
    always_comb begin
        unique case (int_kind)
            K_INSTR:  int_prio = P_INSTR;
            K_PARKED: int_prio = P_PARKED;
            default:  int_prio = P_DATA;
        endcase
    end

    // Strictly-greater rule for the external side
    always_comb begin
        ext_wins     = !int_req || (ext_prio > int_prio);
        int_reclaims = int_req && (int_prio >= ext_prio);
    end

endmodule

// File: rtl/arb_fsm.sv
// Module: arb_fsm
// Four-state ownership machine: idle (parked on the internal side),
// internal owner, external owner, reclaim wait.
// Assumes: req_act and busy_rel are already synchronized to clk.
module arb_fsm
    import arb_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_act,
    input  logic         busy_rel,
    input  logic         int_req,
    input  access_kind_t int_kind,
    input  logic         ext_wins,
    input  logic         int_reclaims,
    output logic         ext_grant_n,
    output logic         busy_drive_en,
    output logic         int_proceed
);

    arb_state_t st, st_nx;

    // Next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (req_act && ext_wins) st_nx = ST_EXT;
                else if (int_req)        st_nx = ST_INT;
            end
            ST_INT: begin
                if (req_act && ext_wins) st_nx = ST_EXT;
                else if (!int_req)       st_nx = ST_IDLE;
            end
            ST_EXT: begin
                if (int_reclaims)            st_nx = ST_WAIT;
                else if (!req_act && busy_rel) st_nx = ST_IDLE;
            end
            ST_WAIT: begin
                if (busy_rel) st_nx = int_req ? ST_INT : ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Output decode from the registered state
    always_comb begin
        ext_grant_n   = (st != ST_EXT);
        busy_drive_en = (st == ST_INT);
        int_proceed   = (st == ST_INT) ||
                        ((st == ST_IDLE) && int_req && (int_kind == K_PARKED));
    end

    // R1: reset leaves grant withdrawn and busy undriven
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ext_grant_n && !busy_drive_en));

    // R3: a grant only starts after a winning synchronized request
    a_r3_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_grant_n) |-> $past(req_act && ext_wins));

    // R7: reclaim wait holds while the external side still drives busy
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !busy_rel) |=> (st == ST_WAIT && ext_grant_n && !busy_drive_en));

    // R8: release by the external master returns to idle
    a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_grant_n && !int_reclaims && !req_act && busy_rel) |=> (st == ST_IDLE));

    // R9: busy is never driven right after a grant was active
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_drive_en) |-> $past(ext_grant_n));

endmodule

// File: rtl/ext_bus_arbiter.sv
// Module: ext_bus_arbiter (top)
// Arbitrates ownership of a shared external bus between the on-chip master
// and one external master using active-low request, grant and busy lines.
// Assumes: ext_req_n and ext_busy_n are asynchronous levels; everything
// else is synchronous to clk.
module ext_bus_arbiter #(
    parameter int PRIO_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req_n,
    input  logic              ext_busy_n,
    input  logic              int_req,
    input  logic [1:0]        int_kind,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic              ext_grant_n,
    output logic              busy_drive_en,
    output logic              int_proceed
);

    import arb_pkg::*;

    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in, sync_out;
    logic             req_act, busy_rel;
    logic             ext_wins, int_reclaims;
    access_kind_t     kind;

    // Pack asynchronous pads for the synchronizer
    assign raw_in = {ext_busy_n, ext_req_n};
    assign kind   = access_kind_t'(int_kind);

    arb_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    // Translate synchronized active-low levels to active-high events
    assign req_act  = !sync_out[0];
    assign busy_rel =  sync_out[1];

    arb_prio #(
        .PRIO_W (PRIO_W)
    ) u_prio (
        .int_req      (int_req),
        .int_kind     (kind),
        .ext_prio     (ext_prio),
        .ext_wins     (ext_wins),
        .int_reclaims (int_reclaims)
    );

    arb_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_act       (req_act),
        .busy_rel      (busy_rel),
        .int_req       (int_req),
        .int_kind      (kind),
        .ext_wins      (ext_wins),
        .int_reclaims  (int_reclaims),
        .ext_grant_n   (ext_grant_n),
        .busy_drive_en (busy_drive_en),
        .int_proceed   (int_proceed)
    );

endmodule

// File: tb/ext_bus_arbiter_bench.sv
// Bench: behavioural reference model compared on every clock.
module ext_bus_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req_n = 1'b1;
    logic       ext_busy_n = 1'b1;
    logic       int_req = 1'b0;
    logic [1:0] int_kind = 2'd0;
    logic [2:0] ext_prio = 3'd0;
    logic       ext_grant_n, busy_drive_en, int_proceed;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state: 0 idle, 1 internal, 2 external, 3 wait
    int   m_st = 0;
    logic rq_q[$];
    logic bb_q[$];

    always #5 clk = ~clk;

    ext_bus_arbiter u_ext_bus_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_req_n     (ext_req_n),
        .ext_busy_n    (ext_busy_n),
        .int_req       (int_req),
        .int_kind      (int_kind),
        .ext_prio      (ext_prio),
        .ext_grant_n   (ext_grant_n),
        .busy_drive_en (busy_drive_en),
        .int_proceed   (int_proceed)
    );

    function automatic int kprio(input logic [1:0] k);
        if (k == 2'd0) return 3;
        if (k == 2'd2) return 0;
        return 4;
    endfunction

    // Advance the model by one rising edge using the inputs now applied
    task automatic model_edge();
        logic use_rq, use_bb;
        int   ip;
        bit   ewins, recl, ract, brel;
        if (!rst_n) begin
            m_st = 0;
            rq_q = '{1'b1, 1'b1};
            bb_q = '{1'b1, 1'b1};
            return;
        end
        use_rq = rq_q.pop_front();
        use_bb = bb_q.pop_front();
        rq_q.push_back(ext_req_n);
        bb_q.push_back(ext_busy_n);
        ip    = kprio(int_kind);
        ewins = !int_req || (int'(ext_prio) > ip);
        recl  = int_req && (ip >= int'(ext_prio));
        ract  = !use_rq;
        brel  = use_bb;
        case (m_st)
            0: m_st = (ract && ewins) ? 2 : (int_req ? 1 : 0);
            1: m_st = (ract && ewins) ? 2 : (!int_req ? 0 : 1);
            2: m_st = recl ? 3 : ((!ract && brel) ? 0 : 2);
            default: m_st = brel ? (int_req ? 1 : 0) : 3;
        endcase
    endtask

    task automatic check(input string tag);
        logic e_bg, e_oe, e_pr;
        e_bg = (m_st != 2);
        e_oe = (m_st == 1);
        e_pr = (m_st == 1) || (m_st == 0 && int_req && int_kind == 2'd2);
        total++;
        if (ext_grant_n !== e_bg || busy_drive_en !== e_oe || int_proceed !== e_pr) begin
            bad++;
            $display("FAIL %s: got bg=%b oe=%b pr=%b expected bg=%b oe=%b pr=%b",
                     tag, ext_grant_n, busy_drive_en, int_proceed, e_bg, e_oe, e_pr);
        end
    endtask

    // Explicit single-output expectation, independent of the model
    task automatic expect_bg(input logic exp, input string tag);
        total++;
        if (ext_grant_n !== exp) begin
            bad++;
            $display("FAIL %s: ext_grant_n got %b expected %b", tag, ext_grant_n, exp);
        end
    endtask

    task automatic expect_oe(input logic exp, input string tag);
        total++;
        if (busy_drive_en !== exp) begin
            bad++;
            $display("FAIL %s: busy_drive_en got %b expected %b", tag, busy_drive_en, exp);
        end
    endtask

    // Apply inputs at the falling edge, clock once, compare after
    task automatic step(input logic rq, input logic bb, input logic ir,
                        input logic [1:0] k, input logic [2:0] p, input string tag);
        ext_req_n  = rq;
        ext_busy_n = bb;
        int_req    = ir;
        int_kind   = k;
        ext_prio   = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic hold(input int n, input logic rq, input logic bb, input logic ir,
                        input logic [1:0] k, input logic [2:0] p, input string tag);
        for (int i = 0; i < n; i++) step(rq, bb, ir, k, p, tag);
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        hold(3, 1, 1, 0, 0, 0, "R1 reset");
        expect_bg(1'b1, "R1 reset grant");
        expect_oe(1'b0, "R1 reset busy");
        rst_n = 1'b1;

        // R5: nothing pending stays idle; parked proceeds from idle
        hold(3, 1, 1, 0, 0, 5, "R5 idle");
        step(1, 1, 1, 2'd2, 5, "R5 parked proceed");
        hold(2, 1, 1, 1, 2'd2, 5, "R6 parked owns");
        hold(2, 1, 1, 0, 2'd2, 5, "R6 drop");

        // R3/R2: tie and lower lose, higher wins after sync delay (R4)
        hold(3, 1, 1, 1, 2'd0, 3, "R6 instr own");
        hold(5, 0, 1, 1, 2'd0, 3, "R3 tie keeps internal");
        expect_bg(1'b1, "R3 tie");
        hold(4, 0, 1, 1, 2'd0, 2, "R3 lower");
        step(1, 1, 1, 2'd0, 4, "R4 clear");
        hold(3, 1, 1, 1, 2'd0, 4, "R4 settle");
        step(0, 1, 1, 2'd0, 4, "R4 edge k");
        expect_bg(1'b1, "R4 after k");
        step(0, 1, 1, 2'd0, 4, "R4 edge k+1");
        expect_bg(1'b1, "R4 after k+1");
        step(0, 0, 1, 2'd0, 4, "R9 edge k+2");
        expect_bg(1'b0, "R4 after k+2");
        expect_oe(1'b0, "R9 handover");

        // R7: equal-priority data access reclaims; busy held low keeps wait
        hold(4, 0, 0, 1, 2'd1, 4, "R7 reclaim wait");
        expect_bg(1'b1, "R7 grant withdrawn");
        expect_oe(1'b0, "R7 not driving");
        hold(10, 1, 0, 1, 2'd1, 4, "R7 busy held");
        hold(4, 1, 1, 1, 2'd1, 4, "R7 busy released");
        expect_oe(1'b1, "R7 internal owns");
        hold(2, 1, 1, 0, 2'd1, 4, "R6 back idle");

        // R2: reserved kind acts as data; parked loses to priority 1
        hold(4, 0, 0, 1, 2'd3, 5, "R2 rsvd vs 5");
        hold(4, 0, 0, 1, 2'd3, 4, "R2 rsvd reclaims");
        hold(4, 0, 1, 0, 2'd0, 4, "R7 drop during wait");
        hold(4, 1, 1, 0, 2'd0, 0, "R8 release");
        hold(4, 0, 1, 1, 2'd2, 0, "R2 parked tie");
        hold(4, 0, 0, 1, 2'd2, 1, "R2 parked loses");
        expect_bg(1'b0, "R2 parked loses grant");
        hold(4, 1, 0, 0, 2'd2, 1, "R8 busy still low");
        expect_bg(1'b0, "R8 held by busy");
        hold(4, 1, 1, 0, 2'd2, 1, "R8 released idle");
        expect_bg(1'b1, "R8 idle");

        // R3: no internal request, priority 0 still wins
        hold(4, 0, 0, 0, 2'd0, 0, "R3 no internal");
        expect_bg(1'b0, "R3 prio0 granted");

        // R1: reset in the middle of external ownership
        rst_n = 1'b0;
        step(0, 0, 0, 2'd0, 0, "R1 mid reset");
        expect_bg(1'b1, "R1 mid reset grant");
        rst_n = 1'b1;

        // Random mix, levels held a few cycles each
        for (int i = 0; i < 600; i++) begin
            logic       rq, bb, ir;
            logic [1:0] k;
            logic [2:0] p;
            rq = 1'($urandom_range(0, 1));
            bb = 1'($urandom_range(0, 1));
            ir = 1'($urandom_range(0, 1));
            k  = 2'($urandom_range(0, 3));
            p  = 3'($urandom_range(0, 7));
            hold(int'($urandom_range(1, 5)), rq, bb, ir, k, p, "R3 R7 R8 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule